// File: doc/BRIEF.md
# Dual-Latch Output Compare Channel

This block is one output compare channel that sits beside a reload-based timer. It holds two compare latches. A match on the first (the set latch) drives the waveform pin high. A match on the second (the clear latch) drives it low. Together they produce a pulse or PWM waveform whose edges are placed by the two compare values. The timer and the bus decoding live elsewhere. The channel sees the timer count, the reload value, a running flag and a one-cycle reload pulse. It also sees a write port for each latch, a trigger enable and per-latch interrupt source enables.

Software writes a compare value into a per-latch hold register. While the timer is stopped, the value also goes into the active latch in the same cycle. While the timer runs, it waits in the hold register and enters the active latch at the next reload pulse, so a period is never cut short by a glitch. Each match sets a sticky status flag, which is cleared by writing 1 to it. The interrupt request is raised while any flag whose source enable is set is high. Matches, flags and interrupts keep working when the trigger enable is off; only the waveform pin is frozen. A compare value above the reload value never matches.

Loader state machine, one per latch, states `LD_IDLE` and `LD_PEND`:
- IDLE to IDLE: a write loads at once because the timer is stopped or a reload pulse is present.
- IDLE to PEND: a write arrives while the timer runs.
- PEND to IDLE: a reload pulse arrives, the timer stops, or a write coincides with either of these.
- PEND to PEND: the timer keeps running, and any new write replaces the held value.

Waveform state machine, states `WV_LOW` and `WV_HIGH`:
- DRIVE_HI: trigger enabled, set latch matches alone.
- DRIVE_LO: trigger enabled, clear latch matches alone.
- HOLD: every other case.

Top module: `ocmp_channel`

## Requirements
- R1: A write to a latch while `tmr_run` is 0 loads the active compare value in the same cycle, so it can match as soon as the timer runs.
- R2: A write while `tmr_run` is 1 does not change the active compare value until a cycle with `tmr_wrap` = 1. If the write falls in that same cycle, it takes effect at once.
- R3: With `trig_en` = 1, a match on latch 0 (`wr_sel` = 0) drives `wave_out` high and a match on latch 1 (`wr_sel` = 1) drives it low, one clock after the match.
- R4: If both latches match in the same cycle, `wave_out` keeps its level. Equal compare values are an unsupported setup, and this is the defined result for it.
- R5: A latch whose active value exceeds `tmr_reload` never matches, even when `tmr_count` equals it. Its flag stays 0 and the output holds.
- R6: A latch within range still matches and requests an interrupt while the other latch is out of range.
- R7: With `trig_en` = 0, `wave_out` holds its level, while matches still set flags and raise `irq`.
- R8: `match_flag[k]` is set one clock after a match on latch k and stays set until a cycle with `flag_clr[k]` = 1. If a match and a clear fall in the same cycle, the flag stays set.
- R9: `irq` is 1 exactly while some k has `match_flag[k]` = 1 and `irq_src_en[k]` = 1.
- R10: After reset, `wave_out`, `match_flag` and `irq` are 0.
- R11: No match occurs while `tmr_run` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_count | input | TW | Current timer count |
| tmr_reload | input | TW | Timer reload (setting) value |
| tmr_run | input | 1 | Timer is running |
| tmr_wrap | input | 1 | One-cycle pulse at timer reload |
| wr_en | input | 1 | Compare value write strobe |
| wr_sel | input | 1 | Latch selected by the write: 0 set, 1 clear |
| wr_data | input | TW | Compare value to write |
| flag_clr | input | 2 | Write-1-to-clear for each match flag |
| trig_en | input | 1 | Lets matches drive the waveform pin |
| irq_src_en | input | 2 | Interrupt source enable for each latch |
| wave_out | output | 1 | Waveform pin |
| match_flag | output | 2 | Sticky match status for each latch |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the deferred load. It changes a compare value mid-period and checks that the old value still matches until the reload pulse. A design that loaded at once would match the new value early, and one that never loaded would miss it after the reload. It drives the count onto a value above the reload setting. A design without the range guard would set a flag there. It also turns the trigger off with a match pending and makes a clear coincide with a fresh match, to catch designs that gate the interrupt path along with the pin or let the clear win. Equal compare values check that a simultaneous set and clear leaves the pin where it was.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    typedef enum logic {LD_IDLE, LD_PEND} ld_state_t;
    typedef enum logic {WV_LOW, WV_HIGH} wave_state_t;
    localparam int unsigned NUM_LATCH = 2;
    localparam int unsigned SET_IDX   = 0;
    localparam int unsigned CLR_IDX   = 1;
endpackage

// File: rtl/ocmp_loader.sv
module ocmp_loader
    import ocmp_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tmr_run,
    input  logic          tmr_wrap,
    input  logic          wr_stb,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] act_val
);
    localparam logic [TW-1:0] RST_VAL = {TW{1'b1}};

    ld_state_t     st_q, st_d;
    logic [TW-1:0] hold_q, hold_d;
    logic [TW-1:0] act_q, ld_val;
    logic          ld_now;
    logic          load_ok;

    assign load_ok = !tmr_run || tmr_wrap;

    always_ff @(posedge clk) begin
        if (rst) st_q <= LD_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        hold_d = hold_q;
        ld_now = 1'b0;
        ld_val = hold_q;
        unique case (st_q)
            LD_IDLE: begin
                if (wr_stb) begin
                    hold_d = wr_data;
                    if (load_ok) begin
                        ld_now = 1'b1;
                        ld_val = wr_data;
                    end else begin
                        st_d = LD_PEND;
                    end
                end
            end
            LD_PEND: begin
                if (wr_stb) begin
                    hold_d = wr_data;
                    if (load_ok) begin
                        ld_now = 1'b1;
                        ld_val = wr_data;
                        st_d   = LD_IDLE;
                    end
                end else if (load_ok) begin
                    ld_now = 1'b1;
                    ld_val = hold_q;
                    st_d   = LD_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= RST_VAL;
            act_q  <= RST_VAL;
        end else begin
            hold_q <= hold_d;
            if (ld_now) act_q <= ld_val;
        end
    end

    assign act_val = act_q;

    // R1: a write while stopped lands in the active latch at the next edge
    a_r1_stopped_load: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !tmr_run) |=> (act_q == $past(wr_data)));

    // R2: while running and no reload pulse, the active value is frozen
    a_r2_no_midperiod_load: assert property (@(posedge clk) disable iff (rst)
        (tmr_run && !tmr_wrap) |=> $stable(act_q));
endmodule

// File: rtl/ocmp_matcher.sv
module ocmp_matcher #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tmr_run,
    input  logic [TW-1:0] tmr_count,
    input  logic [TW-1:0] tmr_reload,
    input  logic [TW-1:0] act_val,
    input  logic          clr,
    output logic          hit,
    output logic          flag
);
    logic in_range;
    logic flag_q;

    assign in_range = (act_val <= tmr_reload);
    assign hit      = tmr_run && in_range && (tmr_count == act_val);

    always_ff @(posedge clk) begin
        if (rst)       flag_q <= 1'b0;
        else if (hit)  flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R8: a set flag survives until cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    // R8: a match wins over a coincident clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    // R11: nothing new is flagged while the timer is stopped
    a_r11_idle_no_set: assert property (@(posedge clk) disable iff (rst)
        (!tmr_run && !flag_q) |=> !flag_q);
endmodule

// File: rtl/ocmp_wave_fsm.sv
module ocmp_wave_fsm
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_en,
    input  logic hit_set,
    input  logic hit_clr,
    output logic wave
);
    wave_state_t st_q, st_d;
    logic        drive_hi, drive_lo;

    assign drive_hi = trig_en && hit_set && !hit_clr;
    assign drive_lo = trig_en && hit_clr && !hit_set;

    always_ff @(posedge clk) begin
        if (rst) st_q <= WV_LOW;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WV_LOW:  if (drive_hi) st_d = WV_HIGH;
            WV_HIGH: if (drive_lo) st_d = WV_LOW;
        endcase
    end

    always_comb begin
        unique case (st_q)
            WV_LOW:  wave = 1'b0;
            WV_HIGH: wave = 1'b1;
        endcase
    end

    // R7: a disabled trigger freezes the pin
    a_r7_trig_off_hold: assert property (@(posedge clk) disable iff (rst)
        !trig_en |=> $stable(wave));

    // R4: coincident set and clear leave the pin alone
    a_r4_both_hold: assert property (@(posedge clk) disable iff (rst)
        (hit_set && hit_clr) |=> $stable(wave));

    // R3: set match alone drives high, clear match alone drives low
    a_r3_set_high: assert property (@(posedge clk) disable iff (rst)
        (trig_en && hit_set && !hit_clr) |=> wave);
    a_r3_clr_low: assert property (@(posedge clk) disable iff (rst)
        (trig_en && hit_clr && !hit_set) |=> !wave);
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TW-1:0]        tmr_count,
    input  logic [TW-1:0]        tmr_reload,
    input  logic                 tmr_run,
    input  logic                 tmr_wrap,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [TW-1:0]        wr_data,
    input  logic [NUM_LATCH-1:0] flag_clr,
    input  logic                 trig_en,
    input  logic [NUM_LATCH-1:0] irq_src_en,
    output logic                 wave_out,
    output logic [NUM_LATCH-1:0] match_flag,
    output logic                 irq
);
    logic [TW-1:0]        act [NUM_LATCH];
    logic [NUM_LATCH-1:0] hit;

    for (genvar k = 0; k < NUM_LATCH; k++) begin : g_latch
        logic wr_stb;
        assign wr_stb = wr_en && (wr_sel == 1'(k));

        ocmp_loader #(.TW(TW)) u_load (
            .clk      (clk),
            .rst      (rst),
            .tmr_run  (tmr_run),
            .tmr_wrap (tmr_wrap),
            .wr_stb   (wr_stb),
            .wr_data  (wr_data),
            .act_val  (act[k])
        );

        ocmp_matcher #(.TW(TW)) u_match (
            .clk        (clk),
            .rst        (rst),
            .tmr_run    (tmr_run),
            .tmr_count  (tmr_count),
            .tmr_reload (tmr_reload),
            .act_val    (act[k]),
            .clr        (flag_clr[k]),
            .hit        (hit[k]),
            .flag       (match_flag[k])
        );

        // R5: an out-of-range latch never reports a match
        a_r5_out_of_range_silent: assert property (@(posedge clk) disable iff (rst)
            (act[k] > tmr_reload) |-> !hit[k]);
    end

    ocmp_wave_fsm u_wave (
        .clk     (clk),
        .rst     (rst),
        .trig_en (trig_en),
        .hit_set (hit[SET_IDX]),
        .hit_clr (hit[CLR_IDX]),
        .wave    (wave_out)
    );

    assign irq = |(match_flag & irq_src_en);
endmodule

// File: tb/ocmp_channel_test.sv
module ocmp_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;
    // {clr[1:0], count[7:0], exp_flag[1:0], exp_wave, exp_irq}
    localparam logic [13:0] VEC [8] = '{
        {2'b00, 8'd100, 2'b00, 1'b0, 1'b0},
        {2'b00, 8'd60,  2'b10, 1'b0, 1'b1},
        {2'b00, 8'd20,  2'b11, 1'b1, 1'b1},
        {2'b11, 8'd5,   2'b00, 1'b1, 1'b0},
        {2'b00, 8'd60,  2'b10, 1'b0, 1'b1},
        {2'b10, 8'd60,  2'b10, 1'b0, 1'b1},
        {2'b10, 8'd40,  2'b00, 1'b0, 1'b0},
        {2'b00, 8'd20,  2'b01, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] tmr_count = '0;
    logic [TW-1:0] tmr_reload = 8'd100;
    logic          tmr_run = 1'b0;
    logic          tmr_wrap = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [TW-1:0] wr_data = '0;
    logic [1:0]    flag_clr = '0;
    logic          trig_en = 1'b1;
    logic [1:0]    irq_src_en = 2'b11;
    logic          wave_out;
    logic [1:0]    match_flag;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocmp_channel #(.TW(TW)) uut (
        .clk(clk), .rst(rst), .tmr_count(tmr_count), .tmr_reload(tmr_reload),
        .tmr_run(tmr_run), .tmr_wrap(tmr_wrap), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .trig_en(trig_en),
        .irq_src_en(irq_src_en), .wave_out(wave_out), .match_flag(match_flag),
        .irq(irq)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [TW-1:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        flag_clr = 2'b11; tmr_count = 8'd0;
        cyc();
        flag_clr = 2'b00;
    endtask

    task automatic at(input logic [TW-1:0] c);
        tmr_count = c;
        cyc();
        tmr_count = 8'd0;
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        chk("R10 wave", int'(wave_out), 0);
        chk("R10 flags", int'(match_flag), 0);
        chk("R10 irq", int'(irq), 0);

        // stopped loads; no match while stopped
        wr(1'b0, 8'd20);
        wr(1'b1, 8'd60);
        at(8'd20);
        chk("R11 stopped no match", int'(match_flag), 0);

        // table walk with the timer running
        tmr_run = 1'b1;
        for (int i = 0; i < 8; i++) begin
            flag_clr  = VEC[i][13:12];
            tmr_count = VEC[i][11:4];
            cyc();
            chk($sformatf("R3/R8/R9 vec%0d flag", i), int'(match_flag), int'(VEC[i][3:2]));
            chk($sformatf("R3 vec%0d wave", i), int'(wave_out), int'(VEC[i][1]));
            chk($sformatf("R9 vec%0d irq", i), int'(irq), int'(VEC[i][0]));
        end
        flag_clr = 2'b00;
        clear_all();

        // R1: stopped write usable at once
        tmr_run = 1'b0;
        wr(1'b0, 8'd30);
        tmr_run = 1'b1;
        at(8'd30);
        chk("R1 immediate load", int'(match_flag), 1);
        clear_all();

        // R2: deferred load while running
        wr(1'b0, 8'd50);
        at(8'd50);
        chk("R2 new value not yet active", int'(match_flag), 0);
        at(8'd30);
        chk("R2 old value still active", int'(match_flag), 1);
        clear_all();
        tmr_wrap = 1'b1; tmr_count = 8'd100;
        cyc();
        tmr_wrap = 1'b0;
        at(8'd50);
        chk("R2 value active after reload", int'(match_flag), 1);
        chk("R2 wave", int'(wave_out), 1);
        clear_all();

        // R5 / R6: clear latch beyond reload
        tmr_run = 1'b0;
        wr(1'b1, 8'd150);
        tmr_run = 1'b1;
        at(8'd150);
        chk("R5 no match above reload", int'(match_flag), 0);
        chk("R5 wave holds", int'(wave_out), 1);
        at(8'd50);
        chk("R6 other latch matches", int'(match_flag), 1);
        chk("R6 irq", int'(irq), 1);
        clear_all();

        // R7: trigger disabled
        tmr_run = 1'b0;
        wr(1'b1, 8'd80);
        tmr_run = 1'b1;
        trig_en = 1'b0;
        at(8'd80);
        chk("R7 wave held", int'(wave_out), 1);
        chk("R7 flag still set", int'(match_flag), 2);
        chk("R7 irq still raised", int'(irq), 1);
        trig_en = 1'b1;
        clear_all();
        at(8'd80);
        chk("R3 clear drives low", int'(wave_out), 0);
        clear_all();

        // R9: source enable masks irq
        irq_src_en = 2'b01;
        at(8'd80);
        chk("R9 masked flag", int'(match_flag), 2);
        chk("R9 masked irq", int'(irq), 0);
        irq_src_en = 2'b11;
        #1;
        chk("R9 unmasked irq", int'(irq), 1);
        clear_all();

        // R4: equal values, both match
        tmr_run = 1'b0;
        wr(1'b0, 8'd70);
        wr(1'b1, 8'd70);
        tmr_run = 1'b1;
        at(8'd70);
        chk("R4 both flags", int'(match_flag), 3);
        chk("R4 wave holds", int'(wave_out), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule